// File: doc/BRIEF.md
# Padded Raster Timing Generator

This block produces the scan timing for a fixed-resolution flat panel that shows a smaller source picture. It runs a horizontal and a vertical position counter over a full output raster, 800 visible pixels by 600 visible lines by default, and decodes from them the two sync pulses and the display-enable flag. Inside that raster a 640 by 512 picture window is anchored at the top-left corner. Only positions inside the window carry picture data. Every other visible position, including the whole band of lines below the picture, is driven black.

The window coordinates go out so that a frame buffer can be asked for the pixel under the beam. The buffer is expected to return the colour word combinationally on `pix_in` in the same cycle. `rgb_out` forwards that word inside the window and holds zero outside it. Front porch, sync width and back porch on both axes, the window size and the sync polarity are all parameters. The total line count is therefore free to make the frame rate land a little below 50 or 60 Hz. With the defaults a line is 1056 pixel clocks and a frame is 628 lines, so a 40 MHz pixel clock gives a line rate near 38 kHz.

Top module: `raster_pad_timing`

## Requirements
- R1: While `rst_n` is low at a rising edge, the position is set to the origin. At the origin both syncs are inactive, `de` and `img_valid` are 1, and `img_x`, `img_y` are 0.
- R2: The horizontal position counts 0 to H_TOTAL-1 in steps of one per clock and then returns to 0. H_TOTAL is H_ACTIVE+H_FP+H_SYNC+H_BP.
- R3: The vertical position advances by one only on the clock that ends a line. After line V_TOTAL-1 it returns to 0. V_TOTAL is V_ACTIVE+V_FP+V_SYNC+V_BP.
- R4: `de` is 1 exactly when the horizontal position is below H_ACTIVE and the vertical position is below V_ACTIVE.
- R5: `hsync` is asserted exactly for horizontal positions from H_ACTIVE+H_FP up to H_ACTIVE+H_FP+H_SYNC-1.
- R6: `vsync` is asserted for all of each line from V_ACTIVE+V_FP up to V_ACTIVE+V_FP+V_SYNC-1. It changes only where a line begins.
- R7: `img_valid` is 1 exactly when the horizontal position is below IMG_W and the vertical position is below IMG_H.
- R8: `img_x` and `img_y` equal the horizontal and vertical positions while `img_valid` is 1, and are 0 otherwise.
- R9: `rgb_out` equals `pix_in` while `img_valid` is 1. It is 0 (black) at every other position, including visible lines at or below IMG_H.
- R10: With SYNC_POS = 1 an asserted sync is driven high. With SYNC_POS = 0 an asserted sync is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_in | input | PIX_W | Colour word returned by the buffer for (`img_x`, `img_y`) |
| hsync | output | 1 | Horizontal sync, polarity set by SYNC_POS |
| vsync | output | 1 | Vertical sync, polarity set by SYNC_POS |
| de | output | 1 | Visible-raster flag |
| img_valid | output | 1 | Position lies inside the picture window |
| img_x | output | clog2(IMG_W) | Picture column for the buffer read |
| img_y | output | clog2(IMG_H) | Picture row for the buffer read |
| rgb_out | output | PIX_W | Colour to the converter, black outside the window |

## Verification
The embedded properties assume a free-running clock with no gaps. They also assume a parameter set in which the window fits inside the visible raster and each porch and sync length is at least one. Under those assumptions the counters never leave their range, and `img_valid` always implies `de`. Reset may be applied at any edge. The stimulus holds to this by using legal, reduced raster sizes on two instances that differ only in sync polarity. It runs them through two whole frames, then applies one reset in mid-frame. `pix_in` is changed on every cycle so that gating can be observed.

// File: rtl/raster_pkg.sv
// raster_pkg: shared helpers for the padded raster timing block.
// Assumes all counts passed in are at least 2.
package raster_pkg;
    // Bit width needed to hold values 0 .. n-1.
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/axis_counter.sv
// axis_counter: position counter for one raster axis.
// Advances on 'step', wraps after TOTAL-1, flags the wrapping clock on 'last'.
// Assumes TOTAL >= 2; reset is synchronous and active low.
module axis_counter #(
    parameter  int TOTAL = 1056,
    localparam int W     = raster_pkg::cnt_w(TOTAL)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] count,
    output logic         last
);
    // Wrap point reached on this advancing clock.
    always_comb last = step && (count == W'(TOTAL - 1));

    // Count register with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (step)
            count <= last ? '0 : count + W'(1);
    end

    assert_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count < W'(TOTAL));
    assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last) |=> count == $past(count) + W'(1));
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count));
    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> count == '0);
endmodule

// File: rtl/sync_window.sv
// sync_window: decodes a sync pulse from an axis position.
// Asserted for START <= count < START+LEN, driven with the chosen polarity.
// Assumes START+LEN does not exceed the axis total.
module sync_window #(
    parameter int W        = 11,
    parameter int START    = 840,
    parameter int LEN      = 128,
    parameter bit SYNC_POS = 1'b1
) (
    input  logic [W-1:0] count,
    output logic         on,
    output logic         pin
);
    // Window membership, polarity-independent.
    always_comb on = (count >= W'(START)) && (count < W'(START + LEN));

    // Polarity variant chosen at elaboration.
    generate
        if (SYNC_POS) begin : g_pos
            always_comb pin = on;
        end else begin : g_neg
            always_comb pin = !on;
        end
    endgenerate
endmodule

// File: rtl/raster_pad_timing.sv
// raster_pad_timing: timing for a padded output raster.
// Runs horizontal/vertical counters, decodes syncs and display enable,
// and gates a top-left picture window of IMG_W x IMG_H; all else is black.
// Assumes IMG_W <= H_ACTIVE, IMG_H <= V_ACTIVE, all porch/sync lengths >= 1,
// and that pix_in arrives combinationally for the presented coordinates.
module raster_pad_timing #(
    parameter  int H_ACTIVE = 800,
    parameter  int H_FP     = 40,
    parameter  int H_SYNC   = 128,
    parameter  int H_BP     = 88,
    parameter  int V_ACTIVE = 600,
    parameter  int V_FP     = 1,
    parameter  int V_SYNC   = 4,
    parameter  int V_BP     = 23,
    parameter  int IMG_W    = 640,
    parameter  int IMG_H    = 512,
    parameter  int PIX_W    = 12,
    parameter  bit SYNC_POS = 1'b1,
    localparam int H_TOTAL  = H_ACTIVE + H_FP + H_SYNC + H_BP,
    localparam int V_TOTAL  = V_ACTIVE + V_FP + V_SYNC + V_BP,
    localparam int HW       = raster_pkg::cnt_w(H_TOTAL),
    localparam int VW       = raster_pkg::cnt_w(V_TOTAL),
    localparam int XW       = raster_pkg::cnt_w(IMG_W),
    localparam int YW       = raster_pkg::cnt_w(IMG_H)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_in,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             img_valid,
    output logic [XW-1:0]    img_x,
    output logic [YW-1:0]    img_y,
    output logic [PIX_W-1:0] rgb_out
);
    localparam int HS_START = H_ACTIVE + H_FP;
    localparam int VS_START = V_ACTIVE + V_FP;

    logic [HW-1:0] hpos;
    logic [VW-1:0] vpos;
    logic          h_last, v_last;
    logic          hs_on, vs_on;

    axis_counter #(.TOTAL(H_TOTAL)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .step(1'b1), .count(hpos), .last(h_last));

    axis_counter #(.TOTAL(V_TOTAL)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .step(h_last), .count(vpos), .last(v_last));

    sync_window #(.W(HW), .START(HS_START), .LEN(H_SYNC), .SYNC_POS(SYNC_POS)) u_hs (
        .count(hpos), .on(hs_on), .pin(hsync));

    sync_window #(.W(VW), .START(VS_START), .LEN(V_SYNC), .SYNC_POS(SYNC_POS)) u_vs (
        .count(vpos), .on(vs_on), .pin(vsync));

    // Visible raster and picture window decode.
    always_comb begin
        de        = (hpos < HW'(H_ACTIVE)) && (vpos < VW'(V_ACTIVE));
        img_valid = (hpos < HW'(IMG_W))    && (vpos < VW'(IMG_H));
    end

    // Buffer request coordinates and black padding.
    always_comb begin
        img_x   = img_valid ? hpos[XW-1:0] : '0;
        img_y   = img_valid ? vpos[YW-1:0] : '0;
        rgb_out = img_valid ? pix_in       : '0;
    end

    assert_window_inside_R7: assert property (@(posedge clk) disable iff (!rst_n)
        img_valid |-> de);
    assert_hsync_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> hpos == HW'(HS_START));
    assert_vsync_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !h_last |=> $stable(vs_on));
    assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        v_last |=> (vpos == '0 && hpos == '0));
    assert_black_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vpos >= VW'(IMG_H)) |-> rgb_out == '0);
endmodule

// File: tb/sim_raster_pad_timing.sv
// sim_raster_pad_timing: sweeps every raster position of a reduced
// configuration over two frames, on both sync polarities, plus a mid-frame reset.
module sim_raster_pad_timing;
    localparam int HA = 20, HF = 2, HS = 3, HB = 4;
    localparam int VA = 10, VF = 1, VS = 2, VB = 2;
    localparam int IW = 12, IH = 7, PW = 12;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PW-1:0] pix = '0;
    logic hs0, vs0, de0, iv0, hs1, vs1, de1, iv1;
    logic [3:0] x0, x1;
    logic [2:0] y0, y1;
    logic [PW-1:0] rgb0, rgb1;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    raster_pad_timing #(.H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
        .IMG_W(IW), .IMG_H(IH), .PIX_W(PW), .SYNC_POS(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .pix_in(pix), .hsync(hs0), .vsync(vs0),
        .de(de0), .img_valid(iv0), .img_x(x0), .img_y(y0), .rgb_out(rgb0));

    raster_pad_timing #(.H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
        .IMG_W(IW), .IMG_H(IH), .PIX_W(PW), .SYNC_POS(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .pix_in(pix), .hsync(hs1), .vsync(vs1),
        .de(de1), .img_valid(iv1), .img_x(x1), .img_y(y1), .rgb_out(rgb1));

    task automatic chk(input string req, input int act, input int exp, input int h, input int v);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at (%0d,%0d): actual %0d expected %0d", req, h, v, act, exp);
        end
    endtask

    // Compare every output of both instances against the arithmetic model at (h,v).
    task automatic check_pos(input int h, input int v);
        bit e_de, e_iv, e_hs, e_vs;
        e_de = (h < HA) && (v < VA);
        e_iv = (h < IW) && (v < IH);
        e_hs = (h >= HA + HF) && (h < HA + HF + HS);
        e_vs = (v >= VA + VF) && (v < VA + VF + VS);
        chk("R4 de",        int'(de0), int'(e_de), h, v);
        chk("R5 hsync",     int'(hs0), int'(e_hs), h, v);
        chk("R6 vsync",     int'(vs0), int'(e_vs), h, v);
        chk("R7 img_valid", int'(iv0), int'(e_iv), h, v);
        chk("R8 img_x",     int'(x0), e_iv ? h : 0, h, v);
        chk("R8 img_y",     int'(y0), e_iv ? v : 0, h, v);
        chk("R9 rgb",       int'(rgb0), e_iv ? int'(pix) : 0, h, v);
        chk("R10 hsync low-active", int'(hs1), int'(!e_hs), h, v);
        chk("R10 vsync low-active", int'(vs1), int'(!e_vs), h, v);
        chk("R10 de same", int'(de1), int'(e_de), h, v);
    endtask

    initial begin
        int h, v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        pix = 12'hABC;
        #1;
        // R1: origin state held during reset
        check_pos(0, 0);
        rst_n = 1'b1;
        h = 0; v = 0;
        // R2, R3: two full frames, every position
        for (int n = 0; n < 2 * HT * VT + 5; n++) begin
            @(negedge clk);
            pix = PW'(n * 37 + 5);
            h++;
            if (h == HT) begin h = 0; v++; if (v == VT) v = 0; end
            #1;
            check_pos(h, v);
        end
        // R1: reset in mid-frame returns to origin
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check_pos(0, 0);
        chk("R1 img_x", int'(x0), 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check_pos(1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule